// File: doc/BRIEF.md
# Branch Resolution Unit

This block resolves one branch per clock for a 64-bit RISC core that numbers bits from the most significant end. Decode supplies a branch kind together with the instruction fields: absolute select, link select, the 5-bit option field, the 5-bit condition-bit index and the displacement. The architectural state comes in beside it: the current instruction address, the 32-bit condition register, the count, link and target registers, and a 64-bit/32-bit mode flag.

Every cycle the unit computes the next instruction address and a taken flag. It also produces a new count value with a write enable and a new link value with a write enable. The results are registered, so each appears on the outputs one clock after its inputs. The core retires these writes to its register file. Fetch, decode, prediction and hint handling belong to other blocks.

Kind codes on `kind`: 0 unconditional, 1 conditional relative/absolute, 2 conditional via link, 3 conditional via count, 4 conditional via target. In the `bo` port, bit 4 is the most significant option bit (OPT0) and bit 0 the least (OPT4): `bo[4]` ignores the condition register, `bo[3]` is the wanted CR bit value, `bo[2]` suppresses the count decrement and test, `bo[1]` selects branch-on-zero, and `bo[0]` is a hint that is not used.

Top module: `brx_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero. Otherwise each output reflects the inputs sampled at the previous rising edge of `clk`.
- R2: The displacement is formed by appending two zero bits and sign-extending to 64 bits. The unconditional kind (0) uses all 24 bits of `disp`. The conditional kind (1) uses `disp[13:0]`. When `aa` is 1 the displacement is the target; when `aa` is 0 the target is `cia` plus the displacement.
- R3: The unconditional kind is always taken and never writes the count register.
- R4: When `lk` is 1, `lr_we` is 1, whether or not the branch is taken; when `lk` is 0, `lr_we` is 0. `lr_new` always carries `cia + 4`.
- R5: For kinds 1, 2 and 4, `ctr_we` is 1 and `ctr_new` is `ctr - 1` when `bo[2]` is 0. When `bo[2]` is 1, `ctr_we` is 0 and `ctr_new` equals `ctr`.
- R6: For kinds 1, 2 and 4 the counter test passes when `bo[2]` is 1. Otherwise it passes when the decremented count is nonzero and `bo[1]` is 0, or when it is zero and `bo[1]` is 1.
- R7: When `mode64` is 1 the zero test covers all 64 bits of the decremented count. When `mode64` is 0 it covers only bits 31:0.
- R8: The CR test passes when `bo[4]` is 1, or when CR bit `bi` equals `bo[3]`. CR bit `bi` is counted from the MSB, so it is `cr[31-bi]`.
- R9: Kinds 1, 2 and 4 are taken only when both the counter test and the CR test pass. A branch that is not taken has a next address of `cia + 4`.
- R10: Kind 2 targets `lr` with bits 1:0 cleared. The target uses the link value held before the instruction, even when `lk` is 1.
- R11: Kind 4 targets `tar` with bits 1:0 cleared.
- R12: Kind 3 never decrements or tests the count. It is taken on the CR test alone, and its target is `ctr` with bits 1:0 cleared.
- R13: When `mode64` is 0, bits 63:32 of `next_addr` and `lr_new` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kind | input | 3 | Branch kind code (0 to 4) |
| aa | input | 1 | Absolute target select |
| lk | input | 1 | Write the link register |
| bo | input | 5 | Branch option field, bit 4 = OPT0 |
| bi | input | 5 | Condition register bit index from the MSB |
| disp | input | 24 | Displacement field; conditional kind uses bits 13:0 |
| cia | input | 64 | Current instruction address |
| cr | input | 32 | Condition register |
| ctr | input | 64 | Count register |
| lr | input | 64 | Link register |
| tar | input | 64 | Target address register |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| next_addr | output | 64 | Next instruction address |
| taken | output | 1 | Branch taken |
| ctr_new | output | 64 | Count register update value |
| ctr_we | output | 1 | Count register write enable |
| lr_new | output | 64 | Link register update value |
| lr_we | output | 1 | Link register write enable |

## Verification
The vector table exercises each target source: relative and absolute displacements with negative values, and register-sourced targets with misaligned low bits. This separates a wrong source or a wrong alignment mask from a wrong sign extension. Counter patterns use counts of 1 and 2 under both zero-test polarities, which separates branch-on-zero from branch-on-nonzero. A count whose decrement is zero in the low half only tells 32-bit mode apart from 64-bit mode. CR patterns probe the first and last bit index with both wanted values, which catches a reversed bit order. A 32-bit-mode case where `cia + 4` carries into bit 32 checks the masking of upper bits. The count-target case with a count of 1 checks that the count is neither decremented nor tested.

// File: rtl/brx_pkg.sv
package brx_pkg;

    typedef enum logic [2:0] {
        BR_ALWAYS     = 3'd0,
        BR_COND       = 3'd1,
        BR_VIA_LINK   = 3'd2,
        BR_VIA_COUNT  = 3'd3,
        BR_VIA_TARGET = 3'd4
    } br_kind_e;

    // Kinds that decrement and test the count register
    function automatic logic kind_uses_count(input br_kind_e k);
        return (k == BR_COND) || (k == BR_VIA_LINK) || (k == BR_VIA_TARGET);
    endfunction

endpackage

// File: rtl/brx_ctr_eval.sv
module brx_ctr_eval #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] ctr,
    input  logic            mode64,
    input  logic            use_count,
    input  logic            skip_count,
    input  logic            on_zero,
    output logic [XLEN-1:0] ctr_next,
    output logic            dec_en,
    output logic            ctr_ok
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] dec;
    logic            nz_full;
    logic            nz_low;
    logic            nz_sel;

    always_comb begin
        dec     = ctr - XLEN'(1);
        nz_full = |dec;
        nz_low  = |dec[HALF-1:0];
        nz_sel  = mode64 ? nz_full : nz_low;
        dec_en  = use_count & ~skip_count;
        ctr_next = dec_en ? dec : ctr;
        if (!use_count || skip_count) begin
            ctr_ok = 1'b1;
        end else begin
            ctr_ok = nz_sel ^ on_zero;
        end
    end
endmodule

// File: rtl/brx_cr_eval.sv
module brx_cr_eval #(
    parameter int CR_W = 32,
    parameter int BI_W = $clog2(CR_W)
) (
    input  logic [CR_W-1:0] cr,
    input  logic [BI_W-1:0] bi,
    input  logic            ignore_cr,
    input  logic            want_bit,
    output logic            cr_ok
);
    logic [BI_W-1:0] pos;

    always_comb begin
        // index counted from the most significant bit
        pos   = BI_W'(CR_W - 1) - bi;
        cr_ok = ignore_cr | (cr[pos] == want_bit);
    end
endmodule

// File: rtl/brx_addr_gen.sv
module brx_addr_gen
    import brx_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int LI_W = 24,
    parameter int BD_W = 14
) (
    input  br_kind_e        kind,
    input  logic            aa,
    input  logic [LI_W-1:0] disp,
    input  logic [XLEN-1:0] cia,
    input  logic [XLEN-1:0] lr,
    input  logic [XLEN-1:0] ctr,
    input  logic [XLEN-1:0] tar,
    input  logic            mode64,
    input  logic            taken,
    output logic [XLEN-1:0] next_addr,
    output logic [XLEN-1:0] link_val
);
    localparam int HALF = XLEN / 2;
    localparam logic [XLEN-1:0] ALIGN = ~XLEN'(3);

    logic [XLEN-1:0] li_off;
    logic [XLEN-1:0] bd_off;
    logic [XLEN-1:0] off;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] tgt;
    logic [XLEN-1:0] seq;
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] hi_mask;

    generate
        if (XLEN > 32) begin : g_mode_mask
            assign hi_mask = mode64 ? '1 : {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};
        end else begin : g_no_mask
            assign hi_mask = '1;
        end
    endgenerate

    always_comb begin
        li_off  = {{(XLEN-LI_W-2){disp[LI_W-1]}}, disp, 2'b00};
        bd_off  = {{(XLEN-BD_W-2){disp[BD_W-1]}}, disp[BD_W-1:0], 2'b00};
        off     = (kind == BR_ALWAYS) ? li_off : bd_off;
        rel_tgt = aa ? off : (cia + off);
        seq     = cia + XLEN'(4);
        unique case (kind)
            BR_ALWAYS, BR_COND: tgt = rel_tgt;
            BR_VIA_LINK:        tgt = lr & ALIGN;
            BR_VIA_COUNT:       tgt = ctr & ALIGN;
            BR_VIA_TARGET:      tgt = tar & ALIGN;
            default:            tgt = seq;
        endcase
        raw       = taken ? tgt : seq;
        next_addr = raw & hi_mask;
        link_val  = seq & hi_mask;
    end
endmodule

// File: rtl/brx_unit.sv
module brx_unit
    import brx_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int CR_W = 32,
    parameter int LI_W = 24,
    parameter int BD_W = 14,
    parameter int BO_W = 5,
    parameter int BI_W = $clog2(CR_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      kind,
    input  logic            aa,
    input  logic            lk,
    input  logic [BO_W-1:0] bo,
    input  logic [BI_W-1:0] bi,
    input  logic [LI_W-1:0] disp,
    input  logic [XLEN-1:0] cia,
    input  logic [CR_W-1:0] cr,
    input  logic [XLEN-1:0] ctr,
    input  logic [XLEN-1:0] lr,
    input  logic [XLEN-1:0] tar,
    input  logic            mode64,
    output logic [XLEN-1:0] next_addr,
    output logic            taken,
    output logic [XLEN-1:0] ctr_new,
    output logic            ctr_we,
    output logic [XLEN-1:0] lr_new,
    output logic            lr_we
);
    // option field positions, OPT0 is the MSB
    localparam int OPT_IGN_CR  = BO_W - 1;
    localparam int OPT_WANT    = BO_W - 2;
    localparam int OPT_NO_CTR  = BO_W - 3;
    localparam int OPT_ON_ZERO = BO_W - 4;

    typedef struct packed {
        logic [XLEN-1:0] next_addr;
        logic            taken;
        logic [XLEN-1:0] ctr_new;
        logic            ctr_we;
        logic [XLEN-1:0] lr_new;
        logic            lr_we;
    } br_res_t;

    br_kind_e        kind_e;
    logic            use_count;
    logic [XLEN-1:0] ctr_next;
    logic            dec_en;
    logic            ctr_ok;
    logic            cr_ok;
    logic            take;
    logic [XLEN-1:0] next_pc;
    logic [XLEN-1:0] link_val;
    logic            unused_hint;
    br_res_t         res_d;
    br_res_t         res_q;
    logic            live_q;

    assign kind_e      = br_kind_e'(kind);
    assign use_count   = kind_uses_count(kind_e);
    assign unused_hint = &{1'b0, bo[0]};

    brx_ctr_eval #(.XLEN(XLEN)) i_ctr (
        .ctr        (ctr),
        .mode64     (mode64),
        .use_count  (use_count),
        .skip_count (bo[OPT_NO_CTR]),
        .on_zero    (bo[OPT_ON_ZERO]),
        .ctr_next   (ctr_next),
        .dec_en     (dec_en),
        .ctr_ok     (ctr_ok)
    );

    brx_cr_eval #(.CR_W(CR_W), .BI_W(BI_W)) i_cr (
        .cr        (cr),
        .bi        (bi),
        .ignore_cr (bo[OPT_IGN_CR]),
        .want_bit  (bo[OPT_WANT]),
        .cr_ok     (cr_ok)
    );

    always_comb begin
        unique case (kind_e)
            BR_ALWAYS:                           take = 1'b1;
            BR_VIA_COUNT:                        take = cr_ok;
            BR_COND, BR_VIA_LINK, BR_VIA_TARGET: take = cr_ok & ctr_ok;
            default:                             take = 1'b0;
        endcase
    end

    brx_addr_gen #(.XLEN(XLEN), .LI_W(LI_W), .BD_W(BD_W)) i_addr (
        .kind      (kind_e),
        .aa        (aa),
        .disp      (disp),
        .cia       (cia),
        .lr        (lr),
        .ctr       (ctr),
        .tar       (tar),
        .mode64    (mode64),
        .taken     (take),
        .next_addr (next_pc),
        .link_val  (link_val)
    );

    always_comb begin
        res_d           = '0;
        res_d.next_addr = next_pc;
        res_d.taken     = take;
        res_d.ctr_new   = ctr_next;
        res_d.ctr_we    = dec_en;
        res_d.lr_new    = link_val;
        res_d.lr_we     = lk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            live_q <= 1'b0;
        end else begin
            res_q  <= res_d;
            live_q <= 1'b1;
        end
    end

    assign next_addr = res_q.next_addr;
    assign taken     = res_q.taken;
    assign ctr_new   = res_q.ctr_new;
    assign ctr_we    = res_q.ctr_we;
    assign lr_new    = res_q.lr_new;
    assign lr_we     = res_q.lr_we;

    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 3'd0) |=> (taken && !ctr_we)); // R3

    AST_LINK_FOLLOWS_LK: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (lr_we == $past(lk))); // R4

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk && mode64) |=> (lr_new == $past(cia) + XLEN'(4))); // R4

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_we |-> (ctr_new == $past(ctr) - XLEN'(1))); // R5

    AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !taken && $past(mode64)) |-> (next_addr == $past(cia) + XLEN'(4))); // R9

    AST_COUNT_KIND_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 3'd3) |=> !ctr_we); // R12

    AST_HIGH_HALF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !mode64 |=> ((next_addr[XLEN-1:XLEN/2] == '0) && (lr_new[XLEN-1:XLEN/2] == '0))); // R13
endmodule

// File: tb/test_brx_unit.sv
`timescale 1ns/1ps
module test_brx_unit;

    typedef struct packed {
        logic [2:0]  kind;
        logic        aa;
        logic        lk;
        logic [4:0]  bo;
        logic [4:0]  bi;
        logic [23:0] disp;
        logic [63:0] cia;
        logic [31:0] cr;
        logic [63:0] ctr;
        logic [63:0] lr;
        logic [63:0] tar;
        logic        m64;
        logic        exp_taken;
    } vec_t;

    typedef struct packed {
        logic [63:0] next_addr;
        logic        taken;
        logic [63:0] ctr_new;
        logic        ctr_we;
        logic [63:0] lr_new;
        logic        lr_we;
    } exp_t;

    localparam logic [63:0] PC  = 64'h0000_0000_0001_0000;
    localparam logic [63:0] PCW = 64'h0000_0001_FFFF_FFFC;
    localparam int NV = 17;

    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 1'b0, 5'b00000, 5'd0,  24'h000010, PC, 32'h0, 64'h9, 64'h0, 64'h0, 1'b1, 1'b1},
        '{3'd0, 1'b1, 1'b1, 5'b00000, 5'd0,  24'hFFFFFF, PC, 32'h0, 64'h9, 64'h0, 64'h0, 1'b1, 1'b1},
        '{3'd1, 1'b0, 1'b0, 5'b10100, 5'd0,  24'h003FFF, PC, 32'h0, 64'h9, 64'h0, 64'h0, 1'b1, 1'b1},
        '{3'd1, 1'b0, 1'b0, 5'b00100, 5'd0,  24'h000008, PC, 32'h7FFF_FFFF, 64'h9, 64'h0, 64'h0, 1'b1, 1'b1},
        '{3'd1, 1'b0, 1'b1, 5'b00100, 5'd0,  24'h000008, PC, 32'h8000_0000, 64'h9, 64'h0, 64'h0, 1'b1, 1'b0},
        '{3'd1, 1'b0, 1'b0, 5'b01100, 5'd31, 24'h000008, PC, 32'h0000_0001, 64'h9, 64'h0, 64'h0, 1'b1, 1'b1},
        '{3'd1, 1'b0, 1'b0, 5'b10000, 5'd0,  24'h000008, PC, 32'h0, 64'h2, 64'h0, 64'h0, 1'b1, 1'b1},
        '{3'd1, 1'b0, 1'b0, 5'b10000, 5'd0,  24'h000008, PC, 32'h0, 64'h1, 64'h0, 64'h0, 1'b1, 1'b0},
        '{3'd1, 1'b0, 1'b0, 5'b10010, 5'd0,  24'h000008, PC, 32'h0, 64'h1, 64'h0, 64'h0, 1'b1, 1'b1},
        '{3'd1, 1'b0, 1'b0, 5'b10000, 5'd0,  24'h000008, PC, 32'h0, 64'h0000_0001_0000_0001, 64'h0, 64'h0, 1'b0, 1'b0},
        '{3'd1, 1'b0, 1'b0, 5'b10000, 5'd0,  24'h000008, PC, 32'h0, 64'h0000_0001_0000_0001, 64'h0, 64'h0, 1'b1, 1'b1},
        '{3'd2, 1'b0, 1'b1, 5'b10100, 5'd0,  24'h0,      PC, 32'h0, 64'h9, 64'h2003, 64'h0, 1'b1, 1'b1},
        '{3'd4, 1'b0, 1'b0, 5'b10100, 5'd0,  24'h0,      PC, 32'h0, 64'h9, 64'h0, 64'h3006, 1'b1, 1'b1},
        '{3'd3, 1'b0, 1'b0, 5'b00000, 5'd0,  24'h0,      PC, 32'h0, 64'h1, 64'h0, 64'h0, 1'b1, 1'b1},
        '{3'd0, 1'b1, 1'b1, 5'b00000, 5'd0,  24'h800000, PCW, 32'h0, 64'h9, 64'h0, 64'h0, 1'b0, 1'b1},
        '{3'd2, 1'b0, 1'b1, 5'b10100, 5'd0,  24'h0,      64'h1000, 32'h0, 64'h9, 64'h8000, 64'h0, 1'b1, 1'b1},
        '{3'd4, 1'b0, 1'b0, 5'b10000, 5'd0,  24'h0,      PC, 32'h0, 64'h1, 64'h0, 64'h7000, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  kind = '0;
    logic        aa = 1'b0;
    logic        lk = 1'b0;
    logic [4:0]  bo = '0;
    logic [4:0]  bi = '0;
    logic [23:0] disp = '0;
    logic [63:0] cia = '0;
    logic [31:0] cr = '0;
    logic [63:0] ctr = '0;
    logic [63:0] lr = '0;
    logic [63:0] tar = '0;
    logic        mode64 = 1'b1;
    logic [63:0] next_addr;
    logic        taken;
    logic [63:0] ctr_new;
    logic        ctr_we;
    logic [63:0] lr_new;
    logic        lr_we;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    brx_unit i_brx_unit (
        .clk (clk), .rst_n (rst_n), .kind (kind), .aa (aa), .lk (lk),
        .bo (bo), .bi (bi), .disp (disp), .cia (cia), .cr (cr),
        .ctr (ctr), .lr (lr), .tar (tar), .mode64 (mode64),
        .next_addr (next_addr), .taken (taken), .ctr_new (ctr_new),
        .ctr_we (ctr_we), .lr_new (lr_new), .lr_we (lr_we)
    );

    // expected results derived from the requirement list
    function automatic exp_t model(input vec_t v);
        exp_t        e;
        logic [63:0] off, dec, tgt, seq, msk;
        logic        ctr_pass, cr_pass, cnt;
        off = (v.kind == 3'd0) ? {{38{v.disp[23]}}, v.disp, 2'b00}
                               : {{48{v.disp[13]}}, v.disp[13:0], 2'b00};
        dec = v.ctr - 64'd1;
        cnt = (v.kind == 3'd1) || (v.kind == 3'd2) || (v.kind == 3'd4);
        ctr_pass = v.bo[2] ? 1'b1 : (((v.m64 ? (dec != 0) : (dec[31:0] != 0))) != v.bo[1]);
        cr_pass  = v.bo[4] || (v.cr[31 - int'(v.bi)] == v.bo[3]);
        seq = v.cia + 64'd4;
        msk = v.m64 ? '1 : 64'h0000_0000_FFFF_FFFF;
        case (v.kind)
            3'd0:    begin e.taken = 1'b1; tgt = v.aa ? off : v.cia + off; end
            3'd1:    begin e.taken = cr_pass && ctr_pass; tgt = v.aa ? off : v.cia + off; end
            3'd2:    begin e.taken = cr_pass && ctr_pass; tgt = {v.lr[63:2], 2'b00}; end
            3'd3:    begin e.taken = cr_pass; tgt = {v.ctr[63:2], 2'b00}; end
            default: begin e.taken = cr_pass && ctr_pass; tgt = {v.tar[63:2], 2'b00}; end
        endcase
        e.next_addr = (e.taken ? tgt : seq) & msk;
        e.ctr_we    = cnt && !v.bo[2];
        e.ctr_new   = e.ctr_we ? dec : v.ctr;
        e.lr_new    = seq & msk;
        e.lr_we     = v.lk;
        return e;
    endfunction

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:    return "R2";
            2:       return "R2";
            3, 5:    return "R8";
            4:       return "R9";
            6:       return "R5";
            7, 8:    return "R6";
            9, 10:   return "R7";
            11, 15:  return "R10";
            12:      return "R11";
            13:      return "R12";
            14:      return "R13";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        kind = v.kind; aa = v.aa; lk = v.lk; bo = v.bo; bi = v.bi;
        disp = v.disp; cia = v.cia; cr = v.cr; ctr = v.ctr; lr = v.lr;
        tar = v.tar; mode64 = v.m64;
    endtask

    task automatic check_all(input string tag, input vec_t v);
        exp_t e;
        e = model(v);
        chk(tag, "taken(table)", {63'd0, taken}, {63'd0, v.exp_taken});
        chk(tag, "taken", {63'd0, taken}, {63'd0, e.taken});
        chk(tag, "next_addr", next_addr, e.next_addr);
        chk(tag, "ctr_we", {63'd0, ctr_we}, {63'd0, e.ctr_we});
        chk(tag, "ctr_new", ctr_new, e.ctr_new);
        chk(tag, "lr_we", {63'd0, lr_we}, {63'd0, e.lr_we});
        chk(tag, "lr_new", lr_new, e.lr_new);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: outputs stay zero during reset even with a taken, linking branch applied
        drive(VECS[1]);
        repeat (3) @(negedge clk);
        chk("R1", "reset next_addr", next_addr, 64'd0);
        chk("R1", "reset flags", {60'd0, taken, ctr_we, lr_we, 1'b0}, 64'd0);
        chk("R1", "reset lr_new", lr_new, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            check_all(vec_tag(i), VECS[i]);
        end

        // R1: one-cycle latency, outputs hold until the next edge
        @(negedge clk);
        drive(VECS[4]);
        #1;
        chk("R1", "hold before edge", next_addr, model(VECS[16]).next_addr);
        @(negedge clk);
        check_all("R1", VECS[4]);

        // R4: conditional not taken without link leaves lr_we low
        @(negedge clk);
        drive(VECS[7]);
        @(negedge clk);
        chk("R4", "lr_we low", {63'd0, lr_we}, 64'd0);
        chk("R9", "fallthrough", next_addr, PC + 64'd4);

        // R1: asynchronous reset mid-run clears outputs
        drive(VECS[1]);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", "mid reset next_addr", next_addr, 64'd0);
        chk("R1", "mid reset lr_we", {63'd0, lr_we}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3", "taken after reset", {63'd0, taken}, 64'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule